// File: doc/BRIEF.md
# Snooping Cache Bus Slave Responder

This block sits beside a small cache line store and answers the shared memory bus whenever its own cache is not the bus master. Every transaction opens with an instruction phase: the master places an opcode and an argument on the bus and raises the new-phase strobe. The responder decodes the opcode on that rising edge and looks the argument up in the line store through a match unit that returns a hit flag and an entry index. On each later rising edge of the strobe it drives a line word, captures a line word, or only acknowledges. It raises its shared output when it owns a copy of a requested line, and it updates the per-entry coherence flags the protocol calls for.

A miss does not let the responder leave the transaction early. It keeps counting phases and acknowledging each one, so the next rising edge it treats as an instruction really is one. A swap-fetch that misses stretches by two phases when any cache drove the shared line during the transaction. The processor side fills entries through a fill port and reads them back through a peek port. There is no valid/ready stream at the edge: the bus is paced by the strobe and by the done acknowledge, so back-pressure is expressed only by holding done low.

Top module: `snoop_slave`

## Requirements
- R1: After reset, done, shared_out and bus_drive are low and every entry's flags read zero.
- R2: The argument carries the real page in its upper RP_W bits and the line offset in its lower OFF_W bits. A lookup hits on the lowest-index entry whose page and offset both equal the argument and whose real-valid flag is set. Entry flags, from bit 4 to bit 0, are virtual-valid, real-valid, entry-dirty, shared and page-dirty.
- R3: A fetch (opcode 0) that hits raises shared_out after the instruction edge. On the next edge it drives word 0 with bus_drive high, on the one after it drives word 1, and it sets the entry's shared flag.
- R4: A fetch or a store (opcode 1) that misses lasts exactly three phases, never drives the bus and leaves shared_out low.
- R5: A store that hits clears the entry's entry-dirty flag and writes the data sampled at the next two edges into word 0 and word 1.
- R6: Every store and every swap-fetch sets the page-dirty flag of all entries whose real page equals the argument's page, whether or not the lookup hits.
- R7: A swap-fetch (opcode 2) that hits sets entry-dirty and raises shared_out. It drives word 0 and then word 1 on the next two edges, captures new words 0 and 1 on the two edges after that, and then ends.
- R8: A swap-fetch that misses lasts three phases, or five phases if shared_in was high in any cycle after its instruction edge.
- R9: Invalidate-virtual (opcode 4) clears virtual-valid, and invalidate-real (opcode 5) clears real-valid, in every entry whose page equals the argument's page.
- R10: Set-map-dirty (opcode 3), write-map-flags (opcode 8) and any undefined opcode last a single phase.
- R11: Write-map (opcode 6) and read-map (opcode 7) last two phases, unless exception_in is pulsed before the second edge, in which case they end at once.
- R12: done falls in the cycle after each edge the responder takes part in and rises one cycle later, holding until the next such edge. shared_out is cleared at the start of every transaction.
- R13: While bus_master is high, a new-phase edge in the idle state starts nothing and changes no flags or outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_master | input | 1 | Own cache currently owns the bus |
| new_phase | input | 1 | Phase strobe; rising edge opens a phase |
| bus_op | input | 4 | Opcode of the instruction phase |
| bus_arg | input | RP_W+OFF_W | Argument: page and offset |
| bus_rdata | input | DW | Data word present on the bus |
| exception_in | input | 1 | Exception pulse from the bus |
| shared_in | input | 1 | Wired shared line as seen on the bus |
| bus_wdata | output | DW | Word this slave drives |
| bus_drive | output | 1 | bus_wdata is valid on the bus |
| shared_out | output | 1 | This cache holds the requested line |
| done | output | 1 | Phase acknowledge |
| fill_en | input | 1 | Write a whole entry |
| fill_idx | input | $clog2(ENTRIES) | Entry to fill |
| fill_rp | input | RP_W | Real page of filled entry |
| fill_off | input | OFF_W | Offset of filled entry |
| fill_flags | input | 5 | Flags of filled entry |
| fill_w0 | input | DW | Word 0 of filled entry |
| fill_w1 | input | DW | Word 1 of filled entry |
| peek_idx | input | $clog2(ENTRIES) | Entry to read back |
| peek_flags | output | 5 | Flags of peeked entry |
| peek_w0 | output | DW | Word 0 of peeked entry |
| peek_w1 | output | DW | Word 1 of peeked entry |

## Verification
The bench goes after phase counting on misses. It sends a fetch-hit instruction on the edge that should still belong to the previous transaction: a responder that ends a miss too early or too late either raises shared_out there or fails to raise it on the following real instruction. The bench pulses shared_in during swap-fetch misses, and it pulses an exception inside a write-map, because getting either rule wrong makes the responder misread the next opcode. Random fetch, store and swap-fetch traffic over entries that share a real page shows whether page-dirty is spread to every matching entry, whether swap-fetch drives the old words before it takes the new ones, and whether an entry without real-valid is wrongly reported as a hit.

// File: rtl/snoop_pkg.sv
package snoop_pkg;
  typedef enum logic [3:0] {
    OP_FETCH   = 4'd0,
    OP_STORE   = 4'd1,
    OP_SWAP    = 4'd2,
    OP_MAPDIRT = 4'd3,
    OP_INV_V   = 4'd4,
    OP_INV_R   = 4'd5,
    OP_WMAP    = 4'd6,
    OP_RMAP    = 4'd7,
    OP_WMFLAG  = 4'd8
  } op_e;

  typedef struct packed {
    logic va_valid;
    logic ra_valid;
    logic ce_dirty;
    logic shared;
    logic rp_dirty;
  } flags_t;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_STORE, S_SWAP, S_DELAY, S_MAP
  } st_e;
endpackage

// File: rtl/snoop_match.sv
module snoop_match #(
  parameter int ENTRIES = 4,
  parameter int RP_W    = 8,
  parameter int OFF_W   = 4,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [RP_W-1:0]    ent_rp  [ENTRIES],
  input  logic [OFF_W-1:0]   ent_off [ENTRIES],
  input  logic [ENTRIES-1:0] ent_rav,
  input  logic [RP_W-1:0]    key_rp,
  input  logic [OFF_W-1:0]   key_off,
  output logic               hit,
  output logic [IDX_W-1:0]   hit_idx,
  output logic [ENTRIES-1:0] page_eq
);
  logic [ENTRIES-1:0] line_hit;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign page_eq[i]  = (ent_rp[i] == key_rp);
    assign line_hit[i] = page_eq[i] && ent_rav[i] && (ent_off[i] == key_off);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (line_hit[i]) hit_idx = IDX_W'(i);
    end
  end

  assign hit = |line_hit;
endmodule

// File: rtl/snoop_lines.sv
module snoop_lines
  import snoop_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int RP_W    = 8,
  parameter int OFF_W   = 4,
  parameter int DW      = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fill_en,
  input  logic [IDX_W-1:0]   fill_idx,
  input  logic [RP_W-1:0]    fill_rp,
  input  logic [OFF_W-1:0]   fill_off,
  input  flags_t             fill_flags,
  input  logic [DW-1:0]      fill_w0,
  input  logic [DW-1:0]      fill_w1,
  input  logic [IDX_W-1:0]   upd_idx,
  input  logic               set_shared,
  input  logic               set_ce,
  input  logic               clr_ce,
  input  logic               wr_en,
  input  logic               wr_sel,
  input  logic [DW-1:0]      wr_data,
  input  logic [ENTRIES-1:0] dirty_mask,
  input  logic [ENTRIES-1:0] va_clr_mask,
  input  logic [ENTRIES-1:0] ra_clr_mask,
  output logic [RP_W-1:0]    ent_rp    [ENTRIES],
  output logic [OFF_W-1:0]   ent_off   [ENTRIES],
  output flags_t             ent_flags [ENTRIES],
  output logic [DW-1:0]      ent_w0    [ENTRIES],
  output logic [DW-1:0]      ent_w1    [ENTRIES],
  output logic [ENTRIES-1:0] ra_vec,
  output logic [ENTRIES-1:0] va_vec
);
  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic sel;
    assign sel       = (upd_idx == IDX_W'(i));
    assign ra_vec[i] = ent_flags[i].ra_valid;
    assign va_vec[i] = ent_flags[i].va_valid;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_rp[i]    <= '0;
        ent_off[i]   <= '0;
        ent_flags[i] <= '0;
        ent_w0[i]    <= '0;
        ent_w1[i]    <= '0;
      end else if (fill_en && fill_idx == IDX_W'(i)) begin
        ent_rp[i]    <= fill_rp;
        ent_off[i]   <= fill_off;
        ent_flags[i] <= fill_flags;
        ent_w0[i]    <= fill_w0;
        ent_w1[i]    <= fill_w1;
      end else begin
        if (dirty_mask[i])       ent_flags[i].rp_dirty <= 1'b1;
        if (va_clr_mask[i])      ent_flags[i].va_valid <= 1'b0;
        if (ra_clr_mask[i])      ent_flags[i].ra_valid <= 1'b0;
        if (sel && set_shared)   ent_flags[i].shared   <= 1'b1;
        if (sel && set_ce)       ent_flags[i].ce_dirty <= 1'b1;
        if (sel && clr_ce)       ent_flags[i].ce_dirty <= 1'b0;
        if (sel && wr_en && !wr_sel) ent_w0[i] <= wr_data;
        if (sel && wr_en &&  wr_sel) ent_w1[i] <= wr_data;
      end
    end
  end

  // R9: a virtual invalidate leaves no targeted entry virtually valid
  p_va_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((|va_clr_mask) && !fill_en) |=> ((va_vec & $past(va_clr_mask)) == '0));
  // R9: same for the real-valid flag
  p_ra_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((|ra_clr_mask) && !fill_en) |=> ((ra_vec & $past(ra_clr_mask)) == '0));
endmodule

// File: rtl/snoop_slave.sv
module snoop_slave
  import snoop_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int RP_W    = 8,
  parameter int OFF_W   = 4,
  parameter int DW      = 32,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int ARG_W  = RP_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_master,
  input  logic             new_phase,
  input  logic [3:0]       bus_op,
  input  logic [ARG_W-1:0] bus_arg,
  input  logic [DW-1:0]    bus_rdata,
  input  logic             exception_in,
  input  logic             shared_in,
  output logic [DW-1:0]    bus_wdata,
  output logic             bus_drive,
  output logic             shared_out,
  output logic             done,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [RP_W-1:0]  fill_rp,
  input  logic [OFF_W-1:0] fill_off,
  input  logic [4:0]       fill_flags,
  input  logic [DW-1:0]    fill_w0,
  input  logic [DW-1:0]    fill_w1,
  input  logic [IDX_W-1:0] peek_idx,
  output logic [4:0]       peek_flags,
  output logic [DW-1:0]    peek_w0,
  output logic [DW-1:0]    peek_w1
);
  logic [RP_W-1:0]    ent_rp    [ENTRIES];
  logic [OFF_W-1:0]   ent_off   [ENTRIES];
  flags_t             ent_flags [ENTRIES];
  logic [DW-1:0]      ent_w0    [ENTRIES];
  logic [DW-1:0]      ent_w1    [ENTRIES];
  logic [ENTRIES-1:0] ra_vec, va_vec, page_eq;
  logic [ENTRIES-1:0] dirty_mask, va_clr_mask, ra_clr_mask;
  logic               hit, set_shared, set_ce, clr_ce, wr_en, wr_sel;
  logic [IDX_W-1:0]   hit_idx, upd_idx, cur_idx;

  st_e        st;
  op_e        op;
  logic       np_prev, np_edge, start, busy_edge, pend, shared_seen, extra;
  logic [2:0] ph;
  logic [1:0] left;

  assign op        = op_e'(bus_op);
  assign np_edge   = new_phase && !np_prev;
  assign start     = np_edge && (st == S_IDLE) && !bus_master;
  assign busy_edge = np_edge && (st != S_IDLE);

  snoop_match #(.ENTRIES(ENTRIES), .RP_W(RP_W), .OFF_W(OFF_W)) u_match (
    .ent_rp(ent_rp), .ent_off(ent_off), .ent_rav(ra_vec),
    .key_rp(bus_arg[ARG_W-1:OFF_W]), .key_off(bus_arg[OFF_W-1:0]),
    .hit(hit), .hit_idx(hit_idx), .page_eq(page_eq)
  );

  snoop_lines #(.ENTRIES(ENTRIES), .RP_W(RP_W), .OFF_W(OFF_W), .DW(DW)) u_lines (
    .clk(clk), .rst_n(rst_n),
    .fill_en(fill_en), .fill_idx(fill_idx), .fill_rp(fill_rp), .fill_off(fill_off),
    .fill_flags(flags_t'(fill_flags)), .fill_w0(fill_w0), .fill_w1(fill_w1),
    .upd_idx(upd_idx), .set_shared(set_shared), .set_ce(set_ce), .clr_ce(clr_ce),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(bus_rdata),
    .dirty_mask(dirty_mask), .va_clr_mask(va_clr_mask), .ra_clr_mask(ra_clr_mask),
    .ent_rp(ent_rp), .ent_off(ent_off), .ent_flags(ent_flags),
    .ent_w0(ent_w0), .ent_w1(ent_w1), .ra_vec(ra_vec), .va_vec(va_vec)
  );

  assign peek_flags = ent_flags[peek_idx];
  assign peek_w0    = ent_w0[peek_idx];
  assign peek_w1    = ent_w1[peek_idx];

  // Flag and line updates requested by the current edge
  always_comb begin
    dirty_mask  = '0;
    va_clr_mask = '0;
    ra_clr_mask = '0;
    set_shared  = 1'b0;
    set_ce      = 1'b0;
    clr_ce      = 1'b0;
    wr_en       = 1'b0;
    wr_sel      = 1'b0;
    upd_idx     = cur_idx;
    if (start) begin
      upd_idx = hit_idx;
      case (op)
        OP_STORE: begin dirty_mask = page_eq; clr_ce = hit; end
        OP_SWAP:  begin dirty_mask = page_eq; set_ce = hit; end
        OP_INV_V: va_clr_mask = page_eq;
        OP_INV_R: ra_clr_mask = page_eq;
        default: ;
      endcase
    end else if (busy_edge) begin
      case (st)
        S_FETCH: set_shared = (ph == 3'd2);
        S_STORE: begin wr_en = 1'b1; wr_sel = (ph == 3'd2); end
        S_SWAP:  begin wr_en = (ph >= 3'd3); wr_sel = (ph == 3'd4); end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      np_prev     <= 1'b0;
      pend        <= 1'b0;
      done        <= 1'b0;
      shared_out  <= 1'b0;
      shared_seen <= 1'b0;
      extra       <= 1'b0;
      bus_drive   <= 1'b0;
      bus_wdata   <= '0;
      cur_idx     <= '0;
      ph          <= '0;
      left        <= '0;
    end else begin
      np_prev <= new_phase;
      if (st != S_IDLE && shared_in) shared_seen <= 1'b1;
      if (start) begin
        done        <= 1'b0;
        pend        <= 1'b1;
        bus_drive   <= 1'b0;
        shared_seen <= 1'b0;
        cur_idx     <= hit_idx;
        ph          <= 3'd1;
        left        <= 2'd2;
        extra       <= (op == OP_SWAP) && !hit;
        shared_out  <= hit && (op == OP_FETCH || op == OP_SWAP);
        case (op)
          OP_FETCH:        st <= hit ? S_FETCH : S_DELAY;
          OP_STORE:        st <= hit ? S_STORE : S_DELAY;
          OP_SWAP:         st <= hit ? S_SWAP  : S_DELAY;
          OP_WMAP, OP_RMAP: st <= S_MAP;
          default:         st <= S_IDLE;
        endcase
      end else if (busy_edge) begin
        done      <= 1'b0;
        pend      <= 1'b1;
        bus_drive <= 1'b0;
        ph        <= ph + 3'd1;
        case (st)
          S_FETCH, S_SWAP: begin
            if (ph == 3'd1) begin bus_wdata <= ent_w0[cur_idx]; bus_drive <= 1'b1; end
            if (ph == 3'd2) begin bus_wdata <= ent_w1[cur_idx]; bus_drive <= 1'b1; end
            if ((st == S_FETCH && ph == 3'd2) || ph == 3'd4) st <= S_IDLE;
          end
          S_STORE: if (ph == 3'd2) st <= S_IDLE;
          S_DELAY: begin
            if (left == 2'd1) begin
              if (extra && (shared_seen || shared_in)) begin
                left  <= 2'd2;
                extra <= 1'b0;
              end else begin
                st <= S_IDLE;
              end
            end else begin
              left <= left - 2'd1;
            end
          end
          default: st <= S_IDLE;
        endcase
      end else begin
        if (pend) begin
          done <= 1'b1;
          pend <= 1'b0;
        end
        if (st == S_MAP && exception_in) st <= S_IDLE;
      end
    end
  end

  // R12: done only falls on a phase edge
  p_done_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done) |-> $past(np_edge));
  // R12: shared_out only rises at a transaction start
  p_shared_start_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shared_out) |-> $past(np_edge && st == S_IDLE));
  // R3: bus driving begins on a phase edge
  p_drive_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_drive) |-> $past(np_edge));
  // R4: a delayed transaction always has phases left
  p_delay_left_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DELAY) |-> (left != 2'd0));
  // R13: while master, an idle edge starts nothing
  p_master_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (np_edge && bus_master && st == S_IDLE) |=> (st == S_IDLE));
endmodule

// File: tb/tb_snoop_slave.sv
module tb_snoop_slave;
  localparam int ENTRIES = 4, RP_W = 8, OFF_W = 4, DW = 32, ARG_W = RP_W + OFF_W;
  localparam logic [4:0] FV = 5'h10, FR = 5'h08, FC = 5'h04, FS = 5'h02, FD = 5'h01;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_master = 0, new_phase = 0, exception_in = 0, shared_in = 0;
  logic [3:0] bus_op = 0;
  logic [ARG_W-1:0] bus_arg = 0;
  logic [DW-1:0] bus_rdata = 0, bus_wdata, fill_w0 = 0, fill_w1 = 0, peek_w0, peek_w1;
  logic bus_drive, shared_out, done, fill_en = 0;
  logic [1:0] fill_idx = 0, peek_idx = 0;
  logic [RP_W-1:0] fill_rp = 0;
  logic [OFF_W-1:0] fill_off = 0;
  logic [4:0] fill_flags = 0, peek_flags;

  int n_chk = 0, n_fail = 0;
  logic mid_done;
  logic [RP_W-1:0] m_rp [ENTRIES];
  logic [OFF_W-1:0] m_off [ENTRIES];
  logic [4:0] m_fl [ENTRIES];
  logic [DW-1:0] m_w0 [ENTRIES], m_w1 [ENTRIES];

  always #2.5 clk = ~clk;

  snoop_slave #(.ENTRIES(ENTRIES), .RP_W(RP_W), .OFF_W(OFF_W), .DW(DW)) dut (.*);

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int find(input logic [ARG_W-1:0] a);
    for (int i = 0; i < ENTRIES; i++)
      if (m_rp[i] == a[ARG_W-1:OFF_W] && m_off[i] == a[OFF_W-1:0] && (m_fl[i] & FR) != 0)
        return i;
    return -1;
  endfunction

  task automatic fill(input int i, input logic [RP_W-1:0] rp, input logic [OFF_W-1:0] off,
                      input logic [4:0] fl);
    @(negedge clk);
    fill_en = 1; fill_idx = 2'(i); fill_rp = rp; fill_off = off; fill_flags = fl;
    fill_w0 = $urandom; fill_w1 = $urandom;
    m_rp[i] = rp; m_off[i] = off; m_fl[i] = fl; m_w0[i] = fill_w0; m_w1[i] = fill_w1;
    @(negedge clk); fill_en = 0;
  endtask

  task automatic phase(input logic [3:0] op, input logic [ARG_W-1:0] arg, input logic [DW-1:0] d);
    @(negedge clk); new_phase = 1; bus_op = op; bus_arg = arg; bus_rdata = d;
    @(negedge clk); new_phase = 0; mid_done = done;
    @(negedge clk);
  endtask

  task automatic verify_lines(input string tag);
    for (int i = 0; i < ENTRIES; i++) begin
      peek_idx = 2'(i); #0.1;
      chk({tag, " flags"}, 32'(peek_flags), 32'(m_fl[i]));
      chk({tag, " w0"}, peek_w0, m_w0[i]);
      chk({tag, " w1"}, peek_w1, m_w1[i]);
    end
  endtask

  // Full fetch / store / swap-fetch transaction against the model
  task automatic txn(input logic [3:0] op, input logic [ARG_W-1:0] arg, input bit shr);
    int idx, nph;
    logic [DW-1:0] d;
    idx = find(arg);
    phase(op, arg, '0);
    chk("R12 done low after edge", 32'(mid_done), 0);
    chk("R12 done high", 32'(done), 1);
    chk("R3/R7 shared_out", 32'(shared_out), 32'(idx >= 0 && op != 4'd1));
    if (op != 4'd0)
      for (int i = 0; i < ENTRIES; i++) if (m_rp[i] == arg[ARG_W-1:OFF_W]) m_fl[i] |= FD; // R6
    if (idx >= 0 && op == 4'd1) m_fl[idx] &= ~FC;
    if (idx >= 0 && op == 4'd2) m_fl[idx] |= FC;
    shared_in = shr;
    nph = (op == 4'd2) ? ((idx >= 0 || shr) ? 4 : 2) : 2;
    for (int k = 1; k <= nph; k++) begin
      d = $urandom;
      phase(4'd0, arg, d);
      if (idx >= 0 && k <= 2 && op != 4'd1) begin
        chk("R3/R7 drive", 32'(bus_drive), 1);
        chk("R3/R7 word", bus_wdata, k == 1 ? m_w0[idx] : m_w1[idx]);
      end else begin
        chk("R4 no drive", 32'(bus_drive), 0);
      end
      if (idx >= 0 && op == 4'd1) begin if (k == 1) m_w0[idx] = d; else m_w1[idx] = d; end // R5
      if (idx >= 0 && op == 4'd2 && k == 3) m_w0[idx] = d;                                 // R7
      if (idx >= 0 && op == 4'd2 && k == 4) m_w1[idx] = d;
    end
    if (idx >= 0 && op == 4'd0) m_fl[idx] |= FS;
    shared_in = 0;
    verify_lines("R5/R6/R7 lines");
  endtask

  // Sends a fetch at entry 0's line: shared_out shows whether it was seen as a new instruction
  task automatic probe(input string tag, input bit expect_new);
    phase(4'd0, {m_rp[0], m_off[0]}, '0);
    chk(tag, 32'(shared_out), 32'(expect_new));
    if (expect_new) begin
      phase(4'd0, 0, 0); phase(4'd0, 0, 0);
      m_fl[0] |= FS;
    end
  endtask

  initial begin
    logic [ARG_W-1:0] a;
    int e;
    void'($urandom(32'd20240611));
    #12; @(negedge clk);
    chk("R1 done", 32'(done), 0);
    chk("R1 shared_out", 32'(shared_out), 0);
    chk("R1 drive", 32'(bus_drive), 0);
    rst_n = 1;
    peek_idx = 2'd1; #0.1; chk("R1 flags", 32'(peek_flags), 0);
    fill(0, 8'h11, 4'h2, FV | FR);
    fill(1, 8'h11, 4'h5, FV | FR | FC);
    fill(2, 8'h22, 4'h2, FV | FR);
    fill(3, 8'h33, 4'h7, FV);            // R2: not real-valid, never hits
    // directed misses and swap-fetch shared extension
    txn(4'd0, {8'h33, 4'h7}, 0);         // R2 miss on non real-valid entry
    probe("R4 fetch miss ends after three phases", 1);
    txn(4'd1, {8'h7F, 4'h0}, 0);
    probe("R4 store miss ends after three phases", 1);
    txn(4'd2, {8'h7F, 4'h1}, 1);
    probe("R8 swap miss with shared lasts five phases", 1);
    txn(4'd2, {8'h7E, 4'h1}, 0);
    probe("R8 swap miss without shared lasts three phases", 1);
    // random traffic
    for (int n = 0; n < 40; n++) begin
      e = $urandom_range(0, 4);
      a = (e == 4) ? {8'h55, 4'(n)} : {m_rp[e], m_off[e]};
      txn(4'($urandom_range(0, 2)), a, 1'($urandom_range(0, 1)));
    end
    // R10 single-phase operations
    phase(4'd3, 0, 0); probe("R10 set-map-dirty one phase", 1);
    phase(4'd8, 0, 0); probe("R10 write-map-flags one phase", 1);
    phase(4'd12, 0, 0); probe("R10 undefined opcode one phase", 1);
    // R11 map operations
    phase(4'd6, 0, 0); probe("R11 write-map delayed phase", 0); probe("R11 write-map ends", 1);
    phase(4'd7, 0, 0);
    @(negedge clk); exception_in = 1; @(negedge clk); exception_in = 0;
    probe("R11 read-map ended by exception", 1);
    // R13 master ignores edges
    txn(4'd1, {8'h7F, 4'h0}, 0);
    bus_master = 1;
    phase(4'd0, {m_rp[0], m_off[0]}, 0);
    chk("R13 shared_out stays low", 32'(shared_out), 0);
    chk("R13 done unchanged", 32'(done), 1);
    phase(4'd5, {m_rp[0], 4'h0}, 0);
    bus_master = 0;
    verify_lines("R13 flags unchanged");
    // R9 invalidates
    phase(4'd4, {8'h11, 4'h0}, 0);
    m_fl[0] &= ~FV; m_fl[1] &= ~FV;
    verify_lines("R9 invalidate virtual");
    phase(4'd5, {8'h22, 4'h9}, 0);
    m_fl[2] &= ~FR;
    verify_lines("R9 invalidate real");
    phase(4'd0, {8'h22, 4'h2}, 0);
    chk("R9 real-invalidated line misses", 32'(shared_out), 0);
    phase(4'd0, 0, 0); phase(4'd0, 0, 0);
    probe("R2 virtual-invalid line still hits", 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #150000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule